// File: doc/BRIEF.md
# Global-History Correlated Branch Direction Predictor

This block predicts whether a conditional branch is taken. Its table has one entry per group of branch addresses, chosen by the low address bits. Each entry holds one saturating counter for every value of a shared history register. That register records the resolved outcomes of the most recent conditional branches. A prediction therefore depends on which branch is asked about and on the path that led to it.

A prediction request carries a branch address. One clock later the block returns the direction and the history value that it used. The branch resolves later. The caller then sends an update with the address, the real outcome and that saved history value. The update trains the counter that made the prediction and shifts the outcome into the history register.

Setting the history length to zero removes the history. The block then becomes a plain per-address predictor built from n-bit counters. The default configuration uses 5 history bits, 2-bit counters and 16 address-selected entries.

Top module: `gh_predictor`

## Requirements
- R1: After reset every counter holds the weakly not-taken value, 2^(n-1)-1, and the history register is zero. A single taken update of a counter therefore makes it predict taken.
- R2: A prediction request is answered one clock later: pred_valid is high in the cycle after pred_req and low in all other cycles. pred_taken and pred_hist keep their values while no request arrives.
- R3: pred_hist returns the history value that the prediction used, which is the value of the history register when the request was sampled.
- R4: The entry is chosen only by address bits [log2(ENTRIES)-1:0]. Addresses that differ only in higher bits share counters.
- R5: Within one entry, the m-bit history selects one of 2^m independent counters. The same address predicts differently under different histories.
- R6: Counters saturate at 0 and at 2^n-1, and the predicted direction is the counter's most significant bit (1 means taken).
- R7: With n=2, a branch that is strongly predicted one way keeps that prediction after one misprediction and flips only after a second consecutive one.
- R8: An update trains the counter selected by upd_pc and the supplied upd_hist, not by the current history register.
- R9: Each update shifts upd_taken into history bit 0. Older bits move one place up and bit m-1 is dropped. Without an update the history does not change.
- R10: With m=0 the block behaves exactly as a per-address table of n-bit counters, and pred_hist is constant zero.
- R11: When a prediction and an update arrive in the same cycle, the prediction uses the counter value and the history value from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_req | input | 1 | Prediction request |
| pred_pc | input | PC_W | Address of the branch to predict |
| pred_valid | output | 1 | Prediction result valid (one cycle after the request) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | max(HIST_BITS,1) | History value used for this prediction |
| upd_en | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_hist | input | max(HIST_BITS,1) | History value returned with the earlier prediction |

## Verification
The hardest case to reach is a given address predicted under a chosen history value. Every update moves the shared history, so a counter trained at one history value is normally read under a different one. The stimulus sets the history to a chosen pattern by issuing updates at an unrelated address whose outcomes spell out that pattern, most significant bit first. It then predicts the trained address and checks both the direction and the returned history. Separate tests train a counter directly through an update carrying an explicit stale history value. A second instance with no history bits runs the same traffic and checks the hysteresis and saturation sequences against fixed expected values.

// File: rtl/gh_predictor.sv
module gh_predictor #(
  parameter int PC_W      = 32,
  parameter int ENTRIES   = 16,
  parameter int HIST_BITS = 5,
  parameter int CTR_BITS  = 2
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        pred_req,
  input  logic [PC_W-1:0]                             pred_pc,
  output logic                                        pred_valid,
  output logic                                        pred_taken,
  output logic [((HIST_BITS > 0) ? HIST_BITS : 1)-1:0] pred_hist,
  input  logic                                        upd_en,
  input  logic [PC_W-1:0]                             upd_pc,
  input  logic                                        upd_taken,
  input  logic [((HIST_BITS > 0) ? HIST_BITS : 1)-1:0] upd_hist
);
  localparam int HW     = (HIST_BITS > 0) ? HIST_BITS : 1;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int SLOT_W = IDX_W + HIST_BITS;
  localparam int SLOTS  = 1 << SLOT_W;
  localparam logic [CTR_BITS-1:0] CMAX  = {CTR_BITS{1'b1}};
  localparam logic [CTR_BITS-1:0] CINIT = CMAX >> 1;

  logic [HW-1:0]       ghist;
  logic [CTR_BITS-1:0] ctr [SLOTS];
  logic [SLOT_W-1:0]   p_slot, u_slot;
  logic                unused_pc;

  assign unused_pc = ^{pred_pc[PC_W-1:IDX_W], upd_pc[PC_W-1:IDX_W]};

  generate
    if (HIST_BITS > 0) begin : g_hist
      assign p_slot = {pred_pc[IDX_W-1:0], ghist};
      assign u_slot = {upd_pc[IDX_W-1:0], upd_hist};
      if (HIST_BITS == 1) begin : g_one
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n)      ghist <= '0;
          else if (upd_en) ghist <= upd_taken;
      end else begin : g_many
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n)      ghist <= '0;
          else if (upd_en) ghist <= {ghist[HW-2:0], upd_taken};
      end
    end else begin : g_nohist
      logic unused_hist;
      assign unused_hist = ^upd_hist;
      assign ghist  = '0;
      assign p_slot = pred_pc[IDX_W-1:0];
      assign u_slot = upd_pc[IDX_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) ctr[i] <= CINIT;
    end else if (upd_en) begin
      if (upd_taken && ctr[u_slot] != CMAX)
        ctr[u_slot] <= ctr[u_slot] + 1'b1;
      else if (!upd_taken && ctr[u_slot] != '0)
        ctr[u_slot] <= ctr[u_slot] - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      pred_hist  <= '0;
    end else begin
      pred_valid <= pred_req;
      if (pred_req) begin
        pred_taken <= ctr[p_slot][CTR_BITS-1];
        pred_hist  <= ghist;
      end
    end
  end
endmodule

module gh_predictor_chk #(
  parameter int HIST_BITS = 5,
  parameter int HW        = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pred_req,
  input logic          pred_valid,
  input logic          pred_taken,
  input logic [HW-1:0] pred_hist,
  input logic [HW-1:0] ghist,
  input logic          upd_en,
  input logic          upd_taken
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    pred_req |=> pred_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_req |=> !pred_valid); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_req |=> ($stable(pred_taken) && $stable(pred_hist))); // R2
  AST_HIST_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    pred_req |=> pred_hist == $past(ghist)); // R3
  AST_HIST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(ghist)); // R9
  generate
    if (HIST_BITS > 0) begin : g_newest
      AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> ghist[0] == $past(upd_taken)); // R9
    end else begin : g_zero
      AST_HIST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> pred_hist == '0); // R10
    end
  endgenerate
endmodule

bind gh_predictor gh_predictor_chk #(.HIST_BITS(HIST_BITS), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .pred_valid(pred_valid),
  .pred_taken(pred_taken), .pred_hist(pred_hist), .ghist(ghist),
  .upd_en(upd_en), .upd_taken(upd_taken));

// File: tb/test_gh_predictor.sv
module test_gh_predictor;
  localparam int PC_W = 32;
  localparam int ENT  = 16;
  localparam int M    = 5;

  typedef struct packed { logic [31:0] pc; logic tk; } vec_t;
  localparam vec_t VEC [16] = '{
    '{32'h100, 1'b1}, '{32'h204, 1'b0}, '{32'h100, 1'b1}, '{32'h204, 1'b1},
    '{32'h100, 1'b0}, '{32'h201, 1'b1}, '{32'h100, 1'b1}, '{32'h204, 1'b0},
    '{32'h301, 1'b1}, '{32'h100, 1'b1}, '{32'h301, 1'b1}, '{32'h100, 1'b0},
    '{32'h202, 1'b1}, '{32'h202, 1'b1}, '{32'h100, 1'b1}, '{32'h202, 1'b0}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic pred_req = 1'b0, upd_en = 1'b0, upd_taken = 1'b0;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic [M-1:0] upd_hist = '0;
  logic pred_valid, pred_taken, v0, t0;
  logic [M-1:0] pred_hist;
  logic h0;

  int total = 0, bad = 0;
  int mc [ENT*32];
  int m0 [ENT];
  logic [M-1:0] mh;
  logic p_tk, p0_tk;
  logic [M-1:0] p_h;

  always #4 clk = ~clk;

  gh_predictor #(.PC_W(PC_W), .ENTRIES(ENT), .HIST_BITS(M), .CTR_BITS(2)) i_gh_predictor (
    .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .pred_pc(pred_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hist(pred_hist),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_hist(upd_hist));

  gh_predictor #(.PC_W(PC_W), .ENTRIES(ENT), .HIST_BITS(0), .CTR_BITS(2)) i_gh_predictor_m0 (
    .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .pred_pc(pred_pc),
    .pred_valid(v0), .pred_taken(t0), .pred_hist(h0),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_hist(1'b0));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int slot(input logic [31:0] pc, input logic [M-1:0] h);
    return int'(pc[3:0]) * 32 + int'(h);
  endfunction

  function automatic int sat(input int c, input logic tk);
    if (tk) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic pred_only(input logic [31:0] pc);
    @(negedge clk); pred_req = 1'b1; pred_pc = pc;
    @(negedge clk); pred_req = 1'b0;
    p_tk = pred_taken; p_h = pred_hist; p0_tk = t0;
    chk(pred_valid == 1'b1 && v0 == 1'b1, "R2", int'(pred_valid), 1);
    chk(p_h == mh, "R3", int'(p_h), int'(mh));
    chk(p0_tk == (m0[pc[3:0]] >= 2), "R10", int'(p0_tk), int'(m0[pc[3:0]] >= 2));
  endtask

  task automatic upd(input logic [31:0] pc, input logic tk, input logic [M-1:0] h);
    @(negedge clk); upd_en = 1'b1; upd_pc = pc; upd_taken = tk; upd_hist = h;
    @(negedge clk); upd_en = 1'b0;
    mc[slot(pc, h)] = sat(mc[slot(pc, h)], tk);
    m0[pc[3:0]] = sat(m0[pc[3:0]], tk);
    mh = {mh[M-2:0], tk};
  endtask

  task automatic branch(input logic [31:0] pc, input logic tk, input string req);
    int e;
    e = (mc[slot(pc, mh)] >= 2) ? 1 : 0;
    pred_only(pc);
    chk(int'(p_tk) == e, req, int'(p_tk), e);
    upd(pc, tk, p_h);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENT*32; i++) mc[i] = 1;
    for (int i = 0; i < ENT; i++) m0[i] = 1;
    mh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R2: reset state
    chk(pred_valid == 1'b0, "R2", int'(pred_valid), 0);
    for (int p = 0; p < 4; p++) begin
      pred_only(32'(p));
      chk(p_tk == 1'b0, "R1", int'(p_tk), 0);
      chk(p_h == '0, "R1", int'(p_h), 0);
    end
    @(negedge clk);
    chk(pred_valid == 1'b0 && v0 == 1'b0, "R2", int'(pred_valid), 0);
    chk(pred_taken == p_tk && pred_hist == p_h, "R2", int'(pred_hist), int'(p_h));

    // R8 + R1: train slot (6, hist=1) while the register is 0; after the shift it is 1
    upd(32'h6, 1'b1, 5'b00001);
    pred_only(32'h6);
    chk(p_tk == 1'b1, "R8", int'(p_tk), 1);
    chk(p_h == 5'b00001, "R9", int'(p_h), 1);
    chk(p0_tk == 1'b1, "R1", int'(p0_tk), 1);

    // R6: saturation at 0 (address 7, no-history instance)
    branch(32'h7, 1'b0, "R6"); branch(32'h7, 1'b0, "R6"); branch(32'h7, 1'b0, "R6");
    branch(32'h7, 1'b1, "R6");
    pred_only(32'h7);
    chk(p0_tk == 1'b0, "R6", int'(p0_tk), 0);
    // R6: saturation at max
    for (int k = 0; k < 4; k++) branch(32'h7, 1'b1, "R6");
    branch(32'h7, 1'b0, "R6");
    pred_only(32'h7);
    chk(p0_tk == 1'b1, "R6", int'(p0_tk), 1);

    // R7: hysteresis on address 5
    for (int k = 0; k < 3; k++) branch(32'h5, 1'b1, "R7");
    branch(32'h5, 1'b0, "R7");
    pred_only(32'h5);
    chk(p0_tk == 1'b1, "R7", int'(p0_tk), 1);
    branch(32'h5, 1'b0, "R7");
    pred_only(32'h5);
    chk(p0_tk == 1'b0, "R7", int'(p0_tk), 0);

    // R4: aliasing through upper address bits
    branch(32'h9, 1'b1, "R4"); branch(32'h9, 1'b1, "R4");
    pred_only(32'h19);
    chk(p0_tk == 1'b1, "R4", int'(p0_tk), 1);
    pred_only(32'h1A);
    chk(p0_tk == 1'b0, "R4", int'(p0_tk), 0);

    // R5: history 01010 trained for address 12, then steered there
    upd(32'hC, 1'b1, 5'b01010);
    upd(32'hC, 1'b1, 5'b01010);
    pred_only(32'hC);
    chk(int'(p_tk) == ((mc[slot(32'hC, mh)] >= 2) ? 1 : 0), "R5", int'(p_tk),
        (mc[slot(32'hC, mh)] >= 2) ? 1 : 0);
    upd(32'hD, 1'b0, mh); upd(32'hD, 1'b1, mh); upd(32'hD, 1'b0, mh);
    upd(32'hD, 1'b1, mh); upd(32'hD, 1'b0, mh);
    pred_only(32'hC);
    chk(p_h == 5'b01010, "R9", int'(p_h), 10);
    chk(p_tk == 1'b1, "R5", int'(p_tk), 1);

    // R11: prediction and update in the same cycle on the same counter (address 14)
    begin
      logic [M-1:0] hb;
      hb = mh;
      @(negedge clk);
      pred_req = 1'b1; pred_pc = 32'hE;
      upd_en = 1'b1; upd_pc = 32'hE; upd_taken = 1'b1; upd_hist = hb;
      @(negedge clk);
      pred_req = 1'b0; upd_en = 1'b0;
      chk(pred_taken == 1'b0, "R11", int'(pred_taken), 0);
      chk(pred_hist == hb, "R11", int'(pred_hist), int'(hb));
      chk(t0 == 1'b0, "R11", int'(t0), 0);
      mc[slot(32'hE, hb)] = sat(mc[slot(32'hE, hb)], 1'b1);
      m0[14] = sat(m0[14], 1'b1);
      mh = {mh[M-2:0], 1'b1};
      pred_only(32'hE);
      chk(p0_tk == 1'b1, "R11", int'(p0_tk), 1);
    end

    // Vector walk: mixed patterns against the bench model
    for (int v = 0; v < 16; v++) branch(VEC[v].pc, VEC[v].tk, "R5");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule